// File: doc/BRIEF.md
# DMA Read Request Header Generator

This block converts a single read-DMA command into a run of PCI Express memory read request headers. Software supplies a 32-bit start address, a total length in doublewords and a level-sensitive start bit. The block divides the transfer into requests of a fixed size, which is 32 doublewords by default. The final request carries whatever count remains. Each request becomes one 128-bit transmit beat that holds a three-doubleword header and no payload. The beats go out on a valid/ready interface.

For every request the block sets the request length, the tag and the address. It copies the requester ID from the live bus, device and function configuration inputs at the moment the beat is loaded. It then moves the address forward by one request's worth of bytes and increments the tag. When the last beat is accepted, `done` pulses for one cycle. After `done`, the block ignores the start bit until software has cleared it, so a start bit that stays high cannot trigger the same command twice. A later rising start issues a new command.

Top module: `dma_rdreq_gen`

## Requirements
- R1: After reset, `tx_valid` and `done` are 0, and the tag counter restarts at 0.
- R2: Header doubleword 0 sits in `tx_data[127:96]`. Its bits [31:14] are all zero: format 00, type 00000, traffic class 000, and the digest and poisoned bits clear. Bit 13 (relaxed ordering) is 1. Bits [12:10] (no-snoop and address type) are 0. Bits [9:0] hold the request length in doublewords, so a full request reads 0x00002020.
- R3: Header doubleword 1 sits in `tx_data[95:64]`. Its bits [31:16] hold {cfg_bus, cfg_dev, cfg_fn}, sampled in the cycle the beat is loaded. Bits [15:8] hold the tag. Bits [7:0] hold the byte enables: 0xFF normally, 0x0F when the length is 1.
- R4: Header doubleword 2 sits in `tx_data[63:32]` and holds the byte address with bits [1:0] forced to 0. `tx_data[31:0]` is 0, and `tx_dw_cnt` is always 3.
- R5: A length L produces ceil(L/32) requests. The first request uses `cmd_addr`. Each later address is the previous one plus 128. Every request has length 32 except the last, which carries the remainder.
- R6: The tag advances by 1 per request, wraps modulo 32, and carries over from one command to the next.
- R7: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` stays 1 and `tx_data` does not change. This holds even if the configuration inputs change.
- R8: `done` is a one-cycle pulse in the cycle after the last beat is accepted, and `tx_valid` is 0 in that cycle.
- R9: A command with length 0 emits no beat and pulses `done` in the cycle after the start is sampled.
- R10: After `done`, a start bit held high produces no beat and no further `done` until it has been seen low.
- R11: With `tx_ready` held high, beats follow one another every cycle. The last acceptance comes L/32 rounded up cycles after the first beat appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Start bit from software, level |
| cmd_addr | input | 32 | Start byte address |
| cmd_len | input | 16 | Total length in doublewords |
| cfg_bus | input | 8 | Configured bus number |
| cfg_dev | input | 5 | Configured device number |
| cfg_fn | input | 3 | Configured function number |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmit sink ready |
| tx_data | output | 128 | Header beat, doublewords 0..2 high to low |
| tx_dw_cnt | output | 3 | Valid doublewords in the beat (always 3) |
| done | output | 1 | One-cycle pulse at command completion |

## Verification
The hardest situation to create from the ports is a beat that is stalled on a low `tx_ready` while the configuration inputs change underneath it. To reach it, the stimulus starts a two-request command with ready held low and switches the bus, device and function numbers during the stall. The held beat must still carry the old ID, and only the next beat may carry the new one. Tag wraparound needs more than 32 requests across commands, so the stimulus includes one long command of 40 requests. Ready is also driven in patterns that alternate and that stall two of every three cycles, so that stalls land both on the first beat and on the remainder beat.

// File: rtl/dma_rdreq_pkg.sv
package dma_rdreq_pkg;

  localparam int HDR_DW = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_HOLD} rdreq_state_e;

  // doubleword 0: memory read, 3DW, no data; relaxed ordering in bit 13
  function automatic logic [31:0] mrd_dw0(input logic [9:0] len);
    logic [31:0] w;
    w = '0;
    w[13]  = 1'b1;
    w[9:0] = len;
    return w;
  endfunction

  // doubleword 1: requester id, tag, last/first byte enables
  function automatic logic [31:0] mrd_dw1(input logic [15:0] rid,
                                          input logic [7:0]  tag,
                                          input logic [9:0]  len);
    logic [3:0] last_be;
    last_be = (len == 10'd1) ? 4'h0 : 4'hF;
    return {rid, tag, last_be, 4'hF};
  endfunction

  // doubleword 2: dword-aligned byte address
  function automatic logic [31:0] mrd_dw2(input logic [31:0] addr);
    return {addr[31:2], 2'b00};
  endfunction

endpackage

// File: rtl/dma_rdreq_seq.sv
module dma_rdreq_seq
  import dma_rdreq_pkg::*;
#(
  parameter int CHUNK_DW = 32,
  parameter int LEN_W    = 16,
  parameter int TAG_W    = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_start,
  input  logic [31:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic             done,
  output logic             beat_load,
  output logic             accept,
  output logic             more_left,
  output logic [31:0]      ld_addr,
  output logic [9:0]       ld_len,
  output logic [TAG_W-1:0] ld_tag
);

  localparam logic [31:0]      STEP_B  = 32'(CHUNK_DW * 4);
  localparam logic [LEN_W-1:0] CHUNK_L = LEN_W'(CHUNK_DW);

  function automatic logic [9:0] chunk_of(input logic [LEN_W-1:0] left_dw);
    return (left_dw >= CHUNK_L) ? 10'(CHUNK_DW) : left_dw[9:0];
  endfunction

  rdreq_state_e     state;
  logic [31:0]      nxt_addr;
  logic [LEN_W-1:0] left;
  logic [TAG_W-1:0] tag;
  logic [31:0]      src_addr;
  logic [LEN_W-1:0] src_left;
  logic             idle_go;

  always_comb begin
    accept    = tx_valid && tx_ready;
    more_left = (left != '0);
    idle_go   = (state == ST_IDLE) && cmd_start && (cmd_len != '0);
    src_addr  = (state == ST_IDLE) ? cmd_addr : nxt_addr;
    src_left  = (state == ST_IDLE) ? cmd_len  : left;
    beat_load = idle_go || (accept && more_left);
    ld_addr   = src_addr;
    ld_len    = chunk_of(src_left);
    ld_tag    = tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tx_valid <= 1'b0;
      done     <= 1'b0;
      tag      <= '0;
      nxt_addr <= '0;
      left     <= '0;
    end else begin
      done <= 1'b0;
      if (beat_load) begin
        nxt_addr <= src_addr + STEP_B;
        left     <= src_left - LEN_W'(ld_len);
        tag      <= tag + TAG_W'(1);
        tx_valid <= 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (cmd_start) begin
            if (cmd_len == '0) begin
              done  <= 1'b1;
              state <= ST_HOLD;
            end else begin
              state <= ST_SEND;
            end
          end
        end
        ST_SEND: begin
          if (accept && !more_left) begin
            tx_valid <= 1'b0;
            done     <= 1'b1;
            state    <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (!cmd_start) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dma_rdreq_fmt.sv
module dma_rdreq_fmt
  import dma_rdreq_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             beat_load,
  input  logic [31:0]      ld_addr,
  input  logic [9:0]       ld_len,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [7:0]       cfg_bus,
  input  logic [4:0]       cfg_dev,
  input  logic [2:0]       cfg_fn,
  output logic [127:0]     tx_data
);

  logic [15:0] req_id;
  logic [7:0]  tag8;

  assign req_id = {cfg_bus, cfg_dev, cfg_fn};
  assign tag8   = 8'(ld_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_data <= '0;
    end else if (beat_load) begin
      tx_data <= {mrd_dw0(ld_len), mrd_dw1(req_id, tag8, ld_len),
                  mrd_dw2(ld_addr), 32'h0};
    end
  end

endmodule

// File: rtl/dma_rdreq_gen.sv
module dma_rdreq_gen
  import dma_rdreq_pkg::*;
#(
  parameter int CHUNK_DW = 32,
  parameter int TAG_W    = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cmd_start,
  input  logic [31:0]  cmd_addr,
  input  logic [15:0]  cmd_len,
  input  logic [7:0]   cfg_bus,
  input  logic [4:0]   cfg_dev,
  input  logic [2:0]   cfg_fn,
  output logic         tx_valid,
  input  logic         tx_ready,
  output logic [127:0] tx_data,
  output logic [2:0]   tx_dw_cnt,
  output logic         done
);

  logic             beat_load;
  logic             accept;
  logic             more_left;
  logic [31:0]      ld_addr;
  logic [9:0]       ld_len;
  logic [TAG_W-1:0] ld_tag;

  assign tx_dw_cnt = 3'(HDR_DW);

  dma_rdreq_seq #(.CHUNK_DW(CHUNK_DW), .LEN_W(16), .TAG_W(TAG_W)) u_seq (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .tx_ready(tx_ready), .tx_valid(tx_valid), .done(done),
    .beat_load(beat_load), .accept(accept), .more_left(more_left),
    .ld_addr(ld_addr), .ld_len(ld_len), .ld_tag(ld_tag)
  );

  dma_rdreq_fmt #(.TAG_W(TAG_W)) u_fmt (
    .clk(clk), .rst(rst), .beat_load(beat_load), .ld_addr(ld_addr),
    .ld_len(ld_len), .ld_tag(ld_tag), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev),
    .cfg_fn(cfg_fn), .tx_data(tx_data)
  );

endmodule

// File: rtl/dma_rdreq_chk.sv
module dma_rdreq_chk #(
  parameter int CHUNK_DW = 32,
  parameter int TAG_W    = 5
) (
  input logic         clk,
  input logic         rst,
  input logic [7:0]   cfg_bus,
  input logic [4:0]   cfg_dev,
  input logic [2:0]   cfg_fn,
  input logic         tx_valid,
  input logic         tx_ready,
  input logic [127:0] tx_data,
  input logic         done,
  input logic         beat_load,
  input logic         accept,
  input logic         more_left
);

  localparam logic [31:0] STEP_B = 32'(CHUNK_DW * 4);

  // R2: fixed fields of doubleword 0 and a legal length
  p_dw0_fields_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_data[127:106] == 22'h8) && (tx_data[105:96] != 10'd0)
                 && (tx_data[105:96] <= 10'(CHUNK_DW)));

  // R3: requester id captured from configuration at load
  p_rid_capture_r3: assert property (@(posedge clk) disable iff (rst)
    beat_load |=> tx_data[95:80] == $past({cfg_bus, cfg_dev, cfg_fn}));

  // R3: first byte enables always all set
  p_first_be_r3: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> tx_data[67:64] == 4'hF);

  // R4: address dword aligned, trailing doubleword zero
  p_tail_zero_r4: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (tx_data[31:0] == 32'h0) && (tx_data[33:32] == 2'b00));

  // R5: address advances by one request per accepted beat
  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    accept && more_left |=> tx_valid && (tx_data[63:32] == $past(tx_data[63:32]) + STEP_B));

  // R6: tag advances by one per request
  p_tag_step_r6: assert property (@(posedge clk) disable iff (rst)
    accept && more_left |=> tx_data[72 +: TAG_W] == $past(tx_data[72 +: TAG_W]) + TAG_W'(1));

  // R7: stalled beat holds
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  // R8: done follows the last acceptance
  p_done_last_r8: assert property (@(posedge clk) disable iff (rst)
    accept && !more_left |=> done && !tx_valid);

  // R8: done lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

bind dma_rdreq_gen dma_rdreq_chk #(.CHUNK_DW(CHUNK_DW), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .done(done),
  .beat_load(beat_load), .accept(accept), .more_left(more_left)
);

// File: tb/dma_rdreq_gen_test.sv
module dma_rdreq_gen_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_start = 1'b0;
  logic [31:0]  cmd_addr = '0;
  logic [15:0]  cmd_len = '0;
  logic [7:0]   cfg_bus = 8'h05;
  logic [4:0]   cfg_dev = 5'h03;
  logic [2:0]   cfg_fn = 3'h1;
  logic         tx_valid;
  logic         tx_ready = 1'b0;
  logic [127:0] tx_data;
  logic [2:0]   tx_dw_cnt;
  logic         done;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [4:0] etag = '0;

  always #4 clk = ~clk;

  dma_rdreq_gen uut (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_dw_cnt(tx_dw_cnt), .done(done)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog: actual=no completion expected=completion");
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] exp_beat(input logic [31:0] a, input int len,
                                            input logic [4:0] t, input logic [15:0] rid);
    logic [31:0] h0, h1, h2;
    h0 = 32'h0000_2000 + 32'(len);
    h1 = {rid, 3'b000, t, (len == 1) ? 8'h0F : 8'hFF};
    h2 = a & 32'hFFFF_FFFC;
    return {h0, h1, h2, 32'h0};
  endfunction

  function automatic bit rdy_of(input int pat, input int k);
    case (pat)
      0: return 1'b1;
      1: return (k % 2) == 0;
      default: return (k % 3) == 2;
    endcase
  endfunction

  // ends a command: check done pulse, then start held high is ignored (R10)
  task automatic finish_cmd(input string name);
    @(negedge clk);
    chk(!done, {"R8 done pulse width ", name}, 128'(done), 128'(0));
    tx_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!tx_valid && !done, {"R10 start held ", name}, 128'({tx_valid, done}), 128'(0));
    end
    cmd_start = 1'b0;
    tx_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [31:0] a, input int len, input int pat,
                         input string name);
    int nb, got, k, left, cl;
    logic [31:0] ea;
    logic [127:0] held, exp;
    bit hv, fin;
    logic [15:0] rid;
    nb = (len + 31) / 32;
    got = 0; k = 0; left = len; ea = a; hv = 0; fin = 0;
    rid = {cfg_bus, cfg_dev, cfg_fn};
    @(negedge clk);
    cmd_addr = a; cmd_len = 16'(len); cmd_start = 1'b1; tx_ready = 1'b0;
    while (!fin) begin
      @(negedge clk);
      k++;
      if (hv) chk(tx_valid && tx_data == held, {"R7 hold ", name}, tx_data, held);
      if (done || k > 5000) begin
        fin = 1;
      end else begin
        if (tx_valid) begin
          cl = (left >= 32) ? 32 : left;
          exp = exp_beat(ea, cl, etag, rid);
          chk(tx_data == exp, {"R5 beat content ", name}, tx_data, exp);
        end
        tx_ready = rdy_of(pat, k);
        hv = tx_valid && !tx_ready;
        held = tx_data;
        if (tx_valid && tx_ready) begin
          got++; ea += 32'd128; left -= cl; etag++;
        end
      end
    end
    chk(done && !tx_valid, {"R8 done after last ", name}, 128'({done, tx_valid}), 128'(2));
    chk(got == nb, {"R5 request count ", name}, 128'(got), 128'(nb));
    if (pat == 0) chk(k == nb + 1, {"R11 back-to-back ", name}, 128'(k), 128'(nb + 1));
    finish_cmd(name);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk(!tx_valid && !done, "R1 reset outputs", 128'({tx_valid, done}), 128'(0));
    chk(tx_dw_cnt == 3'd3, "R4 dw count", 128'(tx_dw_cnt), 128'(3));
    rst = 1'b0;
    @(negedge clk);
    chk(!tx_valid && !done, "R1 idle after reset", 128'({tx_valid, done}), 128'(0));
  endtask

  task automatic test_full_dw0();
    @(negedge clk);
    cmd_addr = 32'h0850_D000; cmd_len = 16'd32; cmd_start = 1'b1;
    @(negedge clk);
    chk(tx_valid && tx_data[127:96] == 32'h0000_2020, "R2 dw0 full request",
        128'(tx_data[127:96]), 128'(32'h0000_2020));
    chk(tx_data[95:80] == 16'h0519 && tx_data[71:64] == 8'hFF, "R3 rid and byte enables",
        128'(tx_data[95:64]), 128'({16'h0519, 3'b000, etag, 8'hFF}));
    chk(tx_data[63:32] == 32'h0850_D000 && tx_data[31:0] == 0, "R4 dw2 and tail",
        128'(tx_data[63:0]), 128'({32'h0850_D000, 32'h0}));
    tx_ready = 1'b1;
    etag++;
    @(negedge clk);
    chk(done && !tx_valid, "R8 single request done", 128'({done, tx_valid}), 128'(2));
    finish_cmd("single");
  endtask

  task automatic test_zero_len();
    @(negedge clk);
    cmd_addr = 32'h2000; cmd_len = 16'd0; cmd_start = 1'b1; tx_ready = 1'b1;
    @(negedge clk);
    chk(done && !tx_valid, "R9 zero length done", 128'({done, tx_valid}), 128'(2));
    finish_cmd("zero");
  endtask

  task automatic test_rid_capture();
    logic [127:0] exp;
    cfg_bus = 8'hA1; cfg_dev = 5'h0C; cfg_fn = 3'h2;
    @(negedge clk);
    cmd_addr = 32'h0004_0000; cmd_len = 16'd64; cmd_start = 1'b1; tx_ready = 1'b0;
    @(negedge clk);
    cfg_bus = 8'h3E; cfg_dev = 5'h11; cfg_fn = 3'h7;
    @(negedge clk);
    exp = exp_beat(32'h0004_0000, 32, etag, {8'hA1, 5'h0C, 3'h2});
    chk(tx_valid && tx_data == exp, "R3 R7 id held during stall", tx_data, exp);
    tx_ready = 1'b1;
    @(negedge clk);
    exp = exp_beat(32'h0004_0080, 32, etag + 5'd1, {8'h3E, 5'h11, 3'h7});
    chk(tx_valid && tx_data == exp, "R3 new id on next beat", tx_data, exp);
    etag += 5'd2;
    @(negedge clk);
    chk(done && !tx_valid, "R8 done after two", 128'({done, tx_valid}), 128'(2));
    finish_cmd("rid");
  endtask

  initial begin
    test_reset();
    run_cmd(32'h1000_0000, 64, 0, "two full");
    test_full_dw0();
    run_cmd(32'h0000_8000, 69, 1, "remainder alt");
    run_cmd(32'h0001_0000, 37, 2, "remainder stall");
    run_cmd(32'h0002_0000, 1, 0, "length one");
    test_zero_len();
    run_cmd(32'h0003_0000, 32, 0, "after zero R6");
    test_rid_capture();
    run_cmd(32'h0010_0000, 1280, 0, "tag wrap R6");
    run_cmd(32'h0020_0000, 96, 2, "after wrap");
    summary();
    $finish;
  end

endmodule